// File: doc/BRIEF.md
# Escaped byte-stream to comma decoder

This block turns an 8-bit link byte stream into a 9-bit symbol stream. In the byte stream, control symbols travel as an escape byte followed by a self-checking code byte. Bit 8 of each output symbol tells control symbols (commas) apart from plain data. Ordinary bytes pass through with bit 8 clear. The escape byte is never forwarded.

The byte after an escape is read as a control byte and checked for format. A good code becomes one of four things: a comma, a literal escape data byte, a change to a flow-control status flag, or nothing at all (fill). A malformed control byte is dropped and reported on a one-cycle error pulse. The parser then goes back to reading plain bytes.

Both stream edges use valid/ready. The input transfers a byte in a cycle where `in_valid` and `in_ready` are both high. The output transfers a symbol in a cycle where `out_valid` and `out_ready` are both high. A single output register holds the pending symbol. `in_ready` is low exactly while that register is full and `out_ready` is low. This way no byte is taken that could not be stored, and a held symbol keeps its value until it is taken.

Top module: `esc_comma_decoder`

## Requirements
- R1: A byte other than 8'hCA, accepted while the parser is in plain mode, appears as out_data = {1'b0, byte} with out_valid high in the cycle after acceptance.
- R2: An accepted 8'hCA in plain mode produces no symbol. The next accepted byte is then read as a control byte.
- R3: A control byte has prefix bits 7..6 = 2'b01, code bits 5..3 = c, and check bits 2..0 = ~c. For codes 0 (sop), 1 (eop), 2 (nak) and 3 (attn), the output is the comma {1'b1, 5'b00000, c}.
- R4: A well-formed control byte with code 7 produces the data symbol 9'h0CA.
- R5: A well-formed control byte with code 6 (fill) produces no symbol.
- R6: Code 5 sets xoff_seen and code 4 clears it, from the cycle after acceptance. Neither code produces a symbol. Reset clears xoff_seen.
- R7: A control byte with a wrong prefix, or with check bits that are not the inverse of the code, raises fmt_err for exactly one cycle (the cycle after acceptance). That byte produces no symbol, and the next accepted byte is handled in plain mode.
- R8: in_ready is low exactly when out_valid is high and out_ready is low. While out_valid is high and out_ready is low, out_data stays stable.
- R9: After reset, out_valid, fmt_err and xoff_seen are low, and the parser is in plain mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Output symbol present |
| out_ready | input | 1 | Consumer takes the symbol this cycle |
| out_data | output | 9 | Output symbol; bit 8 set marks a comma |
| fmt_err | output | 1 | One-cycle pulse on a malformed control byte |
| xoff_seen | output | 1 | Last flow-control code was xoff |

## Verification
Each result of an accepted byte (symbol, error pulse, flag change) is due one rising edge after the acceptance edge. in_ready is combinational, so it is due in the same cycle that out_ready changes. The bench drives every input on the falling edge and checks in_ready a moment later. After that it lets the rising edge pass and compares the outputs one time unit after it. A bench reference model updates its expected state at the same point, so each comparison lines up with exactly one edge.

// File: rtl/escdec_pkg.sv
package escdec_pkg;
  localparam int BYTE_W  = 8;
  localparam int SYM_W   = BYTE_W + 1;
  localparam int CODE_W  = 3;
  localparam int PFX_W   = BYTE_W - 2 * CODE_W;
  localparam logic [BYTE_W-1:0] ESC_BYTE = 8'hCA;
  localparam logic [PFX_W-1:0]  CTRL_PFX = 2'b01;

  typedef enum logic [CODE_W-1:0] {
    C_SOP  = 3'd0,
    C_EOP  = 3'd1,
    C_NAK  = 3'd2,
    C_ATTN = 3'd3,
    C_XON  = 3'd4,
    C_XOFF = 3'd5,
    C_FILL = 3'd6,
    C_ESC  = 3'd7
  } ctrl_code_e;

  typedef enum logic {ST_PLAIN, ST_CTRL} parse_st_e;

  typedef struct packed {
    logic       fmt_ok;
    ctrl_code_e code;
  } ctrl_dec_t;
endpackage

// File: rtl/escdec_ctrl_check.sv
module escdec_ctrl_check
  import escdec_pkg::*;
(
  input  logic [BYTE_W-1:0] ctrl_byte,
  output ctrl_dec_t         dec
);
  localparam int CODE_LSB = CODE_W;
  localparam int PFX_LSB  = 2 * CODE_W;

  logic [PFX_W-1:0]  pfx_f;
  logic [CODE_W-1:0] code_f;
  logic [CODE_W-1:0] chk_f;

  always_comb begin
    pfx_f      = ctrl_byte[BYTE_W-1:PFX_LSB];
    code_f     = ctrl_byte[PFX_LSB-1:CODE_LSB];
    chk_f      = ctrl_byte[CODE_W-1:0];
    dec.code   = ctrl_code_e'(code_f);
    dec.fmt_ok = (pfx_f == CTRL_PFX) && (chk_f == ~code_f);
  end
endmodule

// File: rtl/escdec_parser.sv
module escdec_parser
  import escdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              emit,
  output logic [SYM_W-1:0]  emit_sym,
  output logic              fmt_err,
  output logic              xoff_seen
);
  parse_st_e st_q, st_d;
  logic      err_d;
  logic      xoff_d;
  ctrl_dec_t dec;

  escdec_ctrl_check u_chk (
    .ctrl_byte (byte_in),
    .dec       (dec)
  );

  always_comb begin
    st_d     = st_q;
    err_d    = 1'b0;
    xoff_d   = xoff_seen;
    emit     = 1'b0;
    emit_sym = {1'b0, byte_in};
    if (accept) begin
      if (st_q == ST_PLAIN) begin
        if (byte_in == ESC_BYTE) begin
          st_d = ST_CTRL;
        end else begin
          emit = 1'b1;
        end
      end else begin
        st_d = ST_PLAIN;
        if (!dec.fmt_ok) begin
          err_d = 1'b1;
        end else begin
          unique case (dec.code)
            C_SOP, C_EOP, C_NAK, C_ATTN: begin
              emit     = 1'b1;
              emit_sym = {1'b1, {(BYTE_W-CODE_W){1'b0}}, dec.code};
            end
            C_XON:  xoff_d = 1'b0;
            C_XOFF: xoff_d = 1'b1;
            C_FILL: ;
            C_ESC: begin
              emit     = 1'b1;
              emit_sym = {1'b0, ESC_BYTE};
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_PLAIN;
      fmt_err   <= 1'b0;
      xoff_seen <= 1'b0;
    end else begin
      st_q      <= st_d;
      fmt_err   <= err_d;
      xoff_seen <= xoff_d;
    end
  end
endmodule

// File: rtl/escdec_outreg.sv
module escdec_outreg
  import escdec_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SYM_W-1:0] load_sym,
  output logic             can_load,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [SYM_W-1:0] out_data
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_sym;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/esc_comma_decoder.sv
module esc_comma_decoder
  import escdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  out_data,
  output logic              fmt_err,
  output logic              xoff_seen
);
  logic             accept;
  logic             emit;
  logic [SYM_W-1:0] emit_sym;

  assign accept = in_valid && in_ready;

  escdec_parser u_parser (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .byte_in   (in_data),
    .emit      (emit),
    .emit_sym  (emit_sym),
    .fmt_err   (fmt_err),
    .xoff_seen (xoff_seen)
  );

  escdec_outreg u_oreg (
    .clk       (clk),
    .rst       (rst),
    .load      (emit),
    .load_sym  (emit_sym),
    .can_load  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );
endmodule

// File: rtl/escdec_checker.sv
module escdec_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [8:0] out_data,
  input logic       fmt_err,
  input logic       xoff_seen
);
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_comma_shape_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_data[8]) |-> (out_data[7:3] == 5'd0));

  assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> !fmt_err);

  assert_err_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    fmt_err |-> $past(in_valid && in_ready));

  assert_emit_needs_accept_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  assert_xoff_needs_accept_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(xoff_seen) |-> $past(in_valid && in_ready));

  assert_no_raw_escape_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && in_ready && in_data == 8'hCA) && !$past(out_valid && !out_ready)
      && (out_data == 9'h0CA)) |-> !$rose(out_valid) || !$past(fmt_err));
endmodule

bind esc_comma_decoder escdec_checker u_escdec_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .fmt_err   (fmt_err),
  .xoff_seen (xoff_seen)
);

// File: tb/esc_comma_decoder_tb.sv
module esc_comma_decoder_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [8:0] out_data;
  logic       fmt_err;
  logic       xoff_seen;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit       m_full = 0;
  bit [8:0] m_data = '0;
  bit       m_ctrl = 0;
  bit       m_xoff = 0;
  bit       m_err  = 0;

  always #5 clk = ~clk;

  esc_comma_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .fmt_err(fmt_err), .xoff_seen(xoff_seen)
  );

  function automatic bit [7:0] code_byte(input bit [2:0] c);
    return {2'b01, c, ~c};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_byte(input bit [7:0] b);
    if (!m_ctrl) begin
      if (b == 8'hCA) m_ctrl = 1;
      else begin m_full = 1; m_data = {1'b0, b}; end
    end else begin
      m_ctrl = 0;
      if (b[7:6] != 2'b01 || b[2:0] != ~b[5:3]) m_err = 1;
      else case (b[5:3])
        3'd0, 3'd1, 3'd2, 3'd3: begin m_full = 1; m_data = {6'b100000, b[5:3]}; end
        3'd4: m_xoff = 0;
        3'd5: m_xoff = 1;
        3'd6: ;
        default: begin m_full = 1; m_data = 9'h0CA; end
      endcase
    end
  endtask

  task automatic cyc(input bit iv, input bit [7:0] b, input bit ordy, input string tag);
    bit rdy;
    @(negedge clk);
    in_valid = iv; in_data = b; out_ready = ordy;
    #1;
    rdy = !(m_full && !ordy);
    chk(in_ready == rdy, {tag, " R8 in_ready"}, in_ready, rdy);
    if (m_full && ordy) m_full = 0;
    m_err = 0;
    if (iv && rdy) model_byte(b);
    @(posedge clk);
    #1;
    chk(out_valid == m_full, {tag, " out_valid"}, out_valid, m_full);
    if (m_full) chk(out_data == m_data, {tag, " out_data"}, out_data, m_data);
    chk(fmt_err == m_err, {tag, " R7 fmt_err"}, fmt_err, m_err);
    chk(xoff_seen == m_xoff, {tag, " R6 xoff_seen"}, xoff_seen, m_xoff);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(out_valid == 0, "R9 reset out_valid", out_valid, 0);
    chk(fmt_err == 0, "R9 reset fmt_err", fmt_err, 0);
    chk(xoff_seen == 0, "R9 reset xoff_seen", xoff_seen, 0);
    chk(in_ready == 1, "R9 reset in_ready", in_ready, 1);
    // R9: plain mode after reset, so a code byte passes as data
    cyc(1, code_byte(3'd0), 1, "R9 plain after reset");
    cyc(1, 8'h5A, 1, "R1 plain byte");
    cyc(1, 8'hCA, 1, "R2 escape swallowed");
    cyc(1, code_byte(3'd1), 1, "R3 eop comma");
    for (int c = 0; c < 4; c++) begin
      cyc(1, 8'hCA, 1, "R2 escape");
      cyc(1, code_byte(c[2:0]), 1, "R3 comma");
    end
    cyc(1, 8'hCA, 1, "R4 escape");
    cyc(1, code_byte(3'd7), 1, "R4 literal escape");
    cyc(1, 8'hCA, 1, "R5 escape");
    cyc(1, code_byte(3'd6), 1, "R5 fill dropped");
    cyc(1, 8'hCA, 1, "R6 escape");
    cyc(1, code_byte(3'd5), 1, "R6 xoff");
    cyc(1, 8'hCA, 1, "R6 escape");
    cyc(1, code_byte(3'd4), 1, "R6 xon");
    cyc(1, 8'hCA, 1, "R7 escape");
    cyc(1, 8'h47 ^ 8'h01, 1, "R7 bad check bits");
    cyc(1, code_byte(3'd0), 1, "R7 back to plain");
    cyc(1, 8'hCA, 1, "R7 escape");
    cyc(1, 8'hCA, 1, "R7 bad prefix");
    cyc(1, 8'hCA, 1, "R7 escape");
    cyc(1, 8'hC7, 1, "R7 bad prefix 11");
    cyc(1, 8'h11, 0, "R8 load then hold");
    cyc(1, 8'h22, 0, "R8 blocked while held");
    cyc(1, 8'h33, 0, "R8 still blocked");
    cyc(1, 8'h44, 1, "R8 release with new byte");
    cyc(0, 8'h00, 1, "R8 drain");
    for (int i = 0; i < 4000; i++) begin
      bit iv, ordy;
      bit [7:0] b;
      iv = ($urandom % 4) != 0;
      ordy = ($urandom % 3) != 0;
      if (m_ctrl) b = (($urandom % 10) < 7) ? code_byte(3'($urandom % 8)) : 8'($urandom);
      else b = (($urandom % 5) == 0) ? 8'hCA : 8'($urandom);
      cyc(iv, b, ordy, "R1 random mix");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule